// File: doc/BRIEF.md
# Multi-Mode Down-Counter Timer Channel

One channel of a bus-programmed 16-bit down-counter timer. The channel has an 8-bit control register, a 16-bit reload ("jam") register and a 16-bit snapshot register for reads. The control register selects one of five counting modes: timeout, strobe, gated one-shot, rate generator and variable duty. It also sets the gate polarity, interrupt enable, run/stop, snapshot freeze and reload request. Software writes the reload value, then writes the control register with the reload bit set. The channel drives a true output, its complement and an active-low interrupt request.

The count clock and the gate are asynchronous inputs. Both pass through a synchronizer in the system clock domain. A count event is a detected falling (trailing) edge of the synchronized count clock, and the counter moves only on such an event while the run bit is set.

Top module: `dct_chan`

## Requirements
- R1: After reset, out_o is 0, out_no is 1, irq_no is 1 and hold_o is 0.
- R2: Write address 0 selects control, 1 the reload low byte and 2 the reload high byte. A control write with bit 7 set drives out_o low and out_no high in the next cycle. On the first count event with a valid gate it loads the reload value into the counter. In modes 1, 3 and 5 the load also raises out_o.
- R3: Control bit 3 selects the gate polarity: 1 means the gate is valid when high, 0 means it is valid when low. In modes 1, 2, 4 and 5 an invalid gate blocks both loading and counting.
- R4: Mode 001 (timeout): each count event decrements the counter. When the counter reaches 0, out_o falls. On the next event the counter becomes FFFF and stays there until it is reloaded.
- R5: Control bit 4 enables the interrupt. On a timeout with bit 4 set, irq_no latches low. A control write or reset returns it high. With bit 4 clear, a timeout leaves irq_no high.
- R6: A control write with bit 7 clear leaves the counter value as it was. A write to the reload register never changes a running count.
- R7: Control bit 5 is run. While it is 0, count events neither load nor change the counter.
- R8: A control write with bit 7 set and mode bits 000 reloads the stored reload value and keeps the previous mode.
- R9: Mode 010 (strobe): out_o stays low after the load. It is high for exactly one count event when the counter reaches 0, and the interrupt fires at that point. The counter then becomes FFFF and stops.
- R10: Mode 100 (rate generator): with reload value N ≥ 2, out_o is high for one count event in every N events. The counter reloads automatically at each pulse, and the interrupt fires at each pulse.
- R11: Mode 101 (variable duty): the reload high byte gives the number of count events in the high phase and the low byte gives the number in the low phase. out_o toggles at the end of each phase and that phase's byte reloads. The interrupt fires when the high byte reaches 0.
- R12: Mode 011 written with bit 7 clear arms a hardware start and drives out_o low. A gate edge into the valid level loads the counter on the next count event and raises out_o. Counting then continues whatever the gate level. Each further gate edge reloads the counter (retrigger). At 0, out_o falls and the interrupt fires.
- R13: With control bit 6 at 0, hold_o follows the counter. A control write with bit 6 set freezes hold_o. On the next count event hold_o captures the counter value as it was before that event. Each further write of bit 6 set takes one new snapshot in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_clk_i | input | 1 | Count clock, asynchronous |
| gate_i | input | 1 | Gate, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 reload low, 2 reload high |
| wr_data_i | input | 8 | Write data |
| hold_o | output | 16 | Snapshot register (read data) |
| out_o | output | 1 | True output |
| out_no | output | 1 | Complementary output |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Each mode is driven with short reload values and stepped one count event at a time. This separates a counter that loads from one that decrements on the load event. It also exposes off-by-one errors in the phase and pulse lengths. The gate is run through both polarities, held invalid and toggled during a one-shot. This separates level enabling from edge triggering and shows whether retrigger reloads the counter. Control writes with the reload bit clear, and writes to the reload register during a run, must leave the count untouched. Snapshot writes taken between count events show whether hold_o freezes, or refreshes on the wrong edge.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [2:0] {
    MODE_NONE    = 3'b000,
    MODE_TIMEOUT = 3'b001,
    MODE_STROBE  = 3'b010,
    MODE_ONESHOT = 3'b011,
    MODE_RATE    = 3'b100,
    MODE_DUTY    = 3'b101
  } mode_e;

  typedef struct packed {
    logic       jam;
    logic       hold;
    logic       run;
    logic       ie;
    logic       pol;
    logic [2:0] mode;
  } ctrl_t;
endpackage

// File: rtl/dct_sync.sv
module dct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/dct_hold.sv
module dct_hold #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          freeze_i,
  input  logic          snap_req_i,
  input  logic          fall_i,
  output logic [CW-1:0] hold_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      pend_q <= 1'b0;
    end else if (snap_req_i) begin
      pend_q <= 1'b1;
    end else if (pend_q && fall_i) begin
      hold_o <= cnt_i;
      pend_q <= 1'b0;
    end else if (!freeze_i) begin
      hold_o <= cnt_i;
    end
  end
endmodule

// File: rtl/dct_core.sv
module dct_core import dct_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic [CW-1:0] jam_i,
  input  logic          ctl_wr_i,
  input  logic          jam_req_i,
  input  logic          arm_req_i,
  input  logic          tick_i,
  input  logic          gate_ok_i,
  input  logic          gate_edge_i,
  output logic [CW-1:0] cnt_o,
  output logic          out_o,
  output logic          evt_o
);
  localparam int HALF = CW / 2;

  logic active_q, load_pend_q, hw_wait_q;
  logic do_load, step, fire;
  logic [HALF-1:0] hi, lo;

  assign hi      = cnt_o[CW-1:HALF];
  assign lo      = cnt_o[HALF-1:0];
  assign do_load = tick_i && load_pend_q && gate_ok_i;
  assign step    = tick_i && !do_load && active_q &&
                   (gate_ok_i || (mode_i == MODE_ONESHOT && hw_wait_q));

  always_comb begin
    fire = 1'b0;
    if (step && !ctl_wr_i) begin
      case (mode_i)
        MODE_TIMEOUT, MODE_ONESHOT, MODE_STROBE: fire = (cnt_o == CW'(1));
        MODE_RATE: fire = (cnt_o <= CW'(1));
        MODE_DUTY: fire = out_o && (hi <= HALF'(1));
        default:   fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      out_o       <= 1'b0;
      active_q    <= 1'b0;
      load_pend_q <= 1'b0;
      hw_wait_q   <= 1'b0;
      evt_o       <= 1'b0;
    end else begin
      evt_o <= fire;
      if (ctl_wr_i) begin
        if (jam_req_i) begin
          load_pend_q <= 1'b1;
          active_q    <= 1'b0;
          hw_wait_q   <= 1'b0;
          out_o       <= 1'b0;
        end else if (arm_req_i) begin
          load_pend_q <= 1'b0;
          active_q    <= 1'b0;
          hw_wait_q   <= 1'b1;
          out_o       <= 1'b0;
        end
      end else begin
        if (do_load) begin
          cnt_o       <= jam_i;
          load_pend_q <= 1'b0;
          active_q    <= 1'b1;
          out_o       <= (mode_i == MODE_TIMEOUT) || (mode_i == MODE_ONESHOT) ||
                         (mode_i == MODE_DUTY);
        end else if (step) begin
          case (mode_i)
            MODE_TIMEOUT, MODE_ONESHOT, MODE_STROBE: begin
              if (cnt_o == '0) begin
                cnt_o    <= '1;
                active_q <= 1'b0;
                out_o    <= 1'b0;
              end else begin
                cnt_o <= cnt_o - CW'(1);
                if (cnt_o == CW'(1)) out_o <= (mode_i == MODE_STROBE);
              end
            end
            MODE_RATE: begin
              if (cnt_o <= CW'(1)) begin
                cnt_o <= jam_i;
                out_o <= 1'b1;
              end else begin
                cnt_o <= cnt_o - CW'(1);
                out_o <= 1'b0;
              end
            end
            MODE_DUTY: begin
              if (out_o) begin
                if (hi <= HALF'(1)) begin
                  cnt_o[CW-1:HALF] <= jam_i[CW-1:HALF];
                  out_o            <= 1'b0;
                end else cnt_o[CW-1:HALF] <= hi - HALF'(1);
              end else begin
                if (lo <= HALF'(1)) begin
                  cnt_o[HALF-1:0] <= jam_i[HALF-1:0];
                  out_o           <= 1'b1;
                end else cnt_o[HALF-1:0] <= lo - HALF'(1);
              end
            end
            default: ;
          endcase
        end
        // hardware start / retrigger
        if (hw_wait_q && gate_edge_i && mode_i == MODE_ONESHOT) load_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dct_chan.sv
module dct_chan import dct_pkg::*; #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cnt_clk_i,
  input  logic           gate_i,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic [2*DW-1:0] hold_o,
  output logic           out_o,
  output logic           out_no,
  output logic           irq_no
);
  localparam int CW = 2 * DW;

  ctrl_t           ctrl_q;
  logic [CW-1:0]   jam_q, cnt;
  logic [1:0]      sync_q;
  logic            cnt_clk_s, gate_s, cnt_clk_d, gate_ok, gate_ok_d;
  logic            gate_edge, cnt_fall, tick, ctl_wr, evt, irq_q, run, ie;
  logic            jam_req, arm_req;

  dct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({gate_i, cnt_clk_i}), .q_o(sync_q)
  );
  assign cnt_clk_s = sync_q[0];
  assign gate_s    = sync_q[1];

  assign run       = ctrl_q.run;
  assign ie        = ctrl_q.ie;
  assign gate_ok   = (gate_s == ctrl_q.pol);
  assign gate_edge = gate_ok && !gate_ok_d;
  assign cnt_fall  = cnt_clk_d && !cnt_clk_s;
  assign tick      = cnt_fall && run;
  assign ctl_wr    = wr_en_i && (wr_addr_i == 2'd0);
  assign jam_req   = wr_data_i[7];
  assign arm_req   = !wr_data_i[7] && (wr_data_i[2:0] == MODE_ONESHOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      jam_q     <= '0;
      cnt_clk_d <= 1'b0;
      gate_ok_d <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      cnt_clk_d <= cnt_clk_s;
      gate_ok_d <= gate_ok;
      if (ctl_wr) begin
        // mode 000 with reload keeps the current mode
        ctrl_q <= ctrl_t'({wr_data_i[7:3],
                  (wr_data_i[7] && wr_data_i[2:0] == 3'b000) ? ctrl_q.mode : wr_data_i[2:0]});
        irq_q  <= 1'b0;
      end else if (evt && ie) begin
        irq_q <= 1'b1;
      end
      if (wr_en_i && wr_addr_i == 2'd1) jam_q[DW-1:0]  <= wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd2) jam_q[CW-1:DW] <= wr_data_i;
    end
  end

  dct_core #(.CW(CW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (ctrl_q.mode),
    .jam_i      (jam_q),
    .ctl_wr_i   (ctl_wr),
    .jam_req_i  (jam_req),
    .arm_req_i  (arm_req),
    .tick_i     (tick),
    .gate_ok_i  (gate_ok),
    .gate_edge_i(gate_edge),
    .cnt_o      (cnt),
    .out_o      (out_o),
    .evt_o      (evt)
  );

  dct_hold #(.CW(CW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .freeze_i  (ctrl_q.hold),
    .snap_req_i(ctl_wr && wr_data_i[6]),
    .fall_i    (cnt_fall),
    .hold_o    (hold_o)
  );

  assign out_no = !out_o;
  assign irq_no = !irq_q;
endmodule

// File: rtl/dct_chan_chk.sv
module dct_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_addr_i,
  input logic [7:0]    wr_data_i,
  input logic          out_o,
  input logic          irq_no,
  input logic          run_i,
  input logic          ie_i,
  input logic          tick_i,
  input logic [CW-1:0] cnt_i
);
  logic ctl_wr, jam_wr;
  assign ctl_wr = wr_en_i && wr_addr_i == 2'd0;
  assign jam_wr = wr_en_i && (wr_addr_i == 2'd1 || wr_addr_i == 2'd2);

  AST_JAM_STAGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wr_data_i[7]) |=> !out_o); // R2

  AST_IRQ_WRITE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> irq_no); // R5

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ie_i); // R5

  AST_JAM_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jam_wr && !tick_i) |=> $stable(cnt_i)); // R6

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ctl_wr) |=> $stable(cnt_i)); // R7
endmodule

bind dct_chan dct_chan_chk #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i[7:0]),
  .out_o    (out_o),
  .irq_no   (irq_no),
  .run_i    (run),
  .ie_i     (ie),
  .tick_i   (tick),
  .cnt_i    (cnt)
);

// File: tb/dct_chan_test.sv
`timescale 1ns/1ps
module dct_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_clk = 1'b0;
  logic        gate = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] hold;
  logic        out, out_n, irq_n;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dct_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .gate_i(gate),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hold_o(hold), .out_o(out), .out_no(out_n), .irq_no(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse();
    cnt_clk = 1'b1; repeat (6) @(negedge clk);
    cnt_clk = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic set_gate(input logic v);
    gate = v; repeat (6) @(negedge clk);
  endtask

  task automatic set_jam(input logic [15:0] v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset();
    chk("R1 out", out, 0); chk("R1 out_n", out_n, 1);
    chk("R1 irq", irq_n, 1); chk("R1 hold", hold, 0);
  endtask

  task automatic t_timeout();
    set_gate(1); set_jam(16'd3);
    wr(2'd0, 8'hB9);
    chk("R2 staged out", out, 0); chk("R2 staged out_n", out_n, 1);
    pulse(); chk("R2 load cnt", hold, 3); chk("R2 load out", out, 1); chk("R2 out_n", out_n, 0);
    pulse(); chk("R4 dec", hold, 2);
    pulse(); chk("R4 dec", hold, 1); chk("R4 out", out, 1);
    pulse(); chk("R4 zero", hold, 0); chk("R4 out low", out, 0); chk("R5 irq", irq_n, 0);
    pulse(); chk("R4 wrap", hold, 16'hFFFF);
    pulse(); chk("R4 stay", hold, 16'hFFFF); chk("R5 irq held", irq_n, 0);
    wr(2'd0, 8'h39); chk("R5 clear", irq_n, 1); chk("R6 no reload", hold, 16'hFFFF);
  endtask

  task automatic t_gate();
    wr(2'd0, 8'hB1);
    pulse(); chk("R3 invalid no load", hold, 16'hFFFF); chk("R3 out", out, 0);
    set_gate(0);
    pulse(); chk("R3 low valid load", hold, 3); chk("R3 out", out, 1);
    set_gate(1);
    pulse(); chk("R3 invalid hold", hold, 3);
  endtask

  task automatic t_run();
    wr(2'd0, 8'h19);
    pulse(); chk("R7 stopped", hold, 3);
    wr(2'd0, 8'h39);
    pulse(); chk("R7 resumed", hold, 2); chk("R6 count kept", out, 1);
  endtask

  task automatic t_jam_running();
    set_jam(16'd9);
    pulse(); chk("R6 jam no effect", hold, 1);
    pulse(); chk("R4 zero", hold, 0); chk("R5 irq", irq_n, 0);
  endtask

  task automatic t_no_ie();
    set_jam(16'd2);
    wr(2'd0, 8'hA9); chk("R5 cleared", irq_n, 1);
    pulse(); pulse(); pulse();
    chk("R5 zero", hold, 0); chk("R5 no irq", irq_n, 1); chk("R4 out", out, 0);
  endtask

  task automatic t_keep_mode();
    wr(2'd0, 8'hB8);
    pulse(); chk("R8 reload", hold, 2); chk("R8 out", out, 1);
    pulse(); chk("R8 mode kept", hold, 1);
    pulse(); chk("R8 timeout", out, 0); chk("R8 irq", irq_n, 0);
  endtask

  task automatic t_strobe();
    wr(2'd0, 8'hBA);
    pulse(); chk("R9 load", hold, 2); chk("R9 out", out, 0);
    pulse(); chk("R9 out", out, 0); chk("R9 irq", irq_n, 1);
    pulse(); chk("R9 pulse", out, 1); chk("R9 irq", irq_n, 0);
    pulse(); chk("R9 end", out, 0); chk("R9 wrap", hold, 16'hFFFF);
  endtask

  task automatic t_rate();
    set_jam(16'd3);
    wr(2'd0, 8'hAC);
    pulse(); chk("R10 load out", out, 0);
    for (int cyc = 0; cyc < 2; cyc++) begin
      pulse(); chk("R10 low", out, 0);
      pulse(); chk("R10 low", out, 0);
      pulse(); chk("R10 pulse", out, 1); chk("R10 reload", hold, 3);
    end
  endtask

  task automatic t_duty();
    set_jam(16'h0201);
    wr(2'd0, 8'hBD);
    pulse(); chk("R11 load", hold, 16'h0201); chk("R11 high", out, 1);
    pulse(); chk("R11 hi dec", hold, 16'h0101); chk("R11 high", out, 1); chk("R11 irq", irq_n, 1);
    pulse(); chk("R11 low", out, 0); chk("R11 hi reload", hold, 16'h0201); chk("R11 irq", irq_n, 0);
    pulse(); chk("R11 high again", out, 1);
    pulse(); chk("R11 hi dec", hold, 16'h0101);
  endtask

  task automatic t_oneshot();
    set_gate(0); set_jam(16'd2);
    wr(2'd0, 8'h3B); chk("R12 armed out", out, 0);
    pulse(); chk("R12 wait", hold, 16'h0101); chk("R12 wait out", out, 0);
    set_gate(1);
    pulse(); chk("R12 start", hold, 2); chk("R12 out", out, 1);
    set_gate(0);
    pulse(); chk("R12 gate free", hold, 1);
    set_gate(1);
    pulse(); chk("R12 retrigger", hold, 2);
    pulse(); chk("R12 dec", hold, 1);
    pulse(); chk("R12 timeout", out, 0); chk("R12 irq", irq_n, 0);
  endtask

  task automatic t_hold();
    set_jam(16'd5);
    wr(2'd0, 8'hB9);
    pulse(); chk("R13 follow", hold, 5);
    wr(2'd0, 8'h79);
    pulse(); chk("R13 snap", hold, 5);
    pulse(); chk("R13 frozen", hold, 5);
    wr(2'd0, 8'h79);
    pulse(); chk("R13 resnap", hold, 3);
    wr(2'd0, 8'h39); chk("R13 release", hold, 2);
    pulse(); chk("R13 follow", hold, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_timeout();
    t_gate();
    t_run();
    t_jam_running();
    t_no_ie();
    t_keep_mode();
    t_strobe();
    t_rate();
    t_duty();
    t_oneshot();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule